// File: doc/BRIEF.md
# Two-Way Message Mailbox with Asymmetric Blocking

This block passes 32-bit messages between an accelerator core and a host bus through two small queues. The inbound queue runs from the host to the core and holds four messages. The outbound queue runs from the core to the host and holds one message. The core talks to the block with request/acknowledge channel accesses. A core read of an empty inbound queue, or a core write to a full outbound queue, holds its request until the block can take it. The core also sees, at all times, how many inbound messages are waiting and how much outbound room is left.

The host side never waits. It issues single-cycle memory-mapped accesses. A host read of the empty outbound queue returns zero and leaves the queue as it was. A host write to the full inbound queue replaces the newest stored message. A status word gives the outbound message count and the inbound free slots.

Addresses on `host_addr`: 0 reads and removes the outbound message; 1 writes an inbound message; 2 reads the status word; 3 is unused.

Top module: `mailbox_pair`

## Requirements
- R1: Messages keep all 32 bits, in both directions.
- R2: The inbound queue holds up to 4 messages. The core receives them oldest first.
- R3: While the inbound queue is empty, `core_rd_req` gets no `core_rd_ack`. Once a message is stored, the held request is acknowledged in the next cycle, with that message on `core_rd_data`.
- R4: While the outbound queue is full and the host is not reading it, `core_wr_req` gets no `core_wr_ack`.
- R5: `core_in_count` shows the stored inbound messages and `core_out_space` shows the free outbound slots, with no request needed. A core read acknowledgement lowers `core_in_count` by one in the next cycle.
- R6: A host read at address 0 while the outbound queue is empty returns zero and changes no count.
- R7: A host write at address 1 while the inbound queue is full, with no core read in that cycle, replaces the newest entry. The count stays at 4 and the older entries are kept.
- R8: A host read at address 2 returns the outbound message count in bits 7:0, the inbound free slots in bits 15:8, and zero in the other bits.
- R9: After reset both queues are empty: `core_in_count` is 0, `core_out_space` is 1, and the status word reads 0x00000400.
- R10: A push and a pop on the same queue in one cycle lose no message and leave the count unchanged. This covers a host write with a core read on the inbound queue, including when it is full. It also covers a core write with a host read on the full outbound queue.
- R11: Host writes to addresses 0, 2 and 3 have no effect. Host reads of addresses 1 and 3 return zero and change no count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_rd_req | input | 1 | Core asks to take an inbound message |
| core_rd_ack | output | 1 | Core read completes this cycle |
| core_rd_data | output | 32 | Oldest inbound message, valid with `core_rd_ack` |
| core_wr_req | input | 1 | Core asks to post an outbound message |
| core_wr_data | input | 32 | Outbound message |
| core_wr_ack | output | 1 | Core write is taken this cycle |
| core_in_count | output | 3 | Inbound messages waiting |
| core_out_space | output | 1 | Free outbound slots |
| host_sel | input | 1 | Host access this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the access cycle |

## Verification
Two pairs of functions can fall in the same cycle. On the inbound queue, a host write can meet a core read acknowledgement. On the outbound queue, the host's read-and-remove can meet a core write that would otherwise stall. Each pair is provoked by driving both sides in one cycle, on a partly filled inbound queue, on a full inbound queue and on a full outbound queue. The result is judged by the count in the following cycle, which must be unchanged, and by draining the queue to confirm that every message comes out in order. A third same-cycle case is also covered: a core read is held on an empty queue while the host writes, and the acknowledgement must arrive only in the next cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic [1:0] {
      MBX_A_OUTMSG = 2'd0,
      MBX_A_INMSG  = 2'd1,
      MBX_A_STATUS = 2'd2,
      MBX_A_SPARE  = 2'd3
   } mbx_addr_e;

   localparam int STAT_FIELD_W = 8;
   localparam int STAT_OUT_LSB = 0;
   localparam int STAT_IN_LSB  = 8;
   localparam int STAT_MAX_DEPTH = (1 << STAT_FIELD_W) - 1;

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
   parameter int W         = 32,
   parameter int DEPTH     = 4,
   parameter bit OVERWRITE = 1'b0,
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot_q;
         logic         valid_q;
         logic         take;

         assign take = push && (!valid_q || pop || OVERWRITE);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot_q  <= '0;
               valid_q <= 1'b0;
            end else if (take) begin
               slot_q  <= push_data;
               valid_q <= 1'b1;
            end else if (pop) begin
               valid_q <= 1'b0;
            end
         end

         assign head  = slot_q;
         assign count = CW'(valid_q);
         assign full  = valid_q;
         assign empty = !valid_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);

         logic [W-1:0]  mem [DEPTH];
         logic [PW-1:0] wr_ptr, rd_ptr;
         logic [CW-1:0] cnt_q;
         logic          do_pop, do_push, do_ovw, room;
         logic [PW-1:0] newest;

         function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
            return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
         endfunction

         assign do_pop  = pop && (cnt_q != '0);
         assign room    = (cnt_q != CW'(DEPTH)) || do_pop;
         assign do_push = push && room;
         assign do_ovw  = push && !room && OVERWRITE;
         assign newest  = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - PW'(1);

         always_ff @(posedge clk) begin
            if (do_push) begin
               mem[wr_ptr] <= push_data;
            end else if (do_ovw) begin
               mem[newest] <= push_data;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_ptr <= '0;
               rd_ptr <= '0;
               cnt_q  <= '0;
            end else begin
               if (do_push) wr_ptr <= ptr_next(wr_ptr);
               if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
               cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
            end
         end

         assign head  = mem[rd_ptr];
         assign count = cnt_q;
         assign full  = (cnt_q == CW'(DEPTH));
         assign empty = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/mbx_host_if.sv
module mbx_host_if
   import mbx_pkg::*;
#(
   parameter int W         = 32,
   parameter int IN_DEPTH  = 4,
   parameter int OUT_DEPTH = 1,
   localparam int ICW      = $clog2(IN_DEPTH + 1),
   localparam int OCW      = $clog2(OUT_DEPTH + 1)
) (
   input  logic           host_sel,
   input  logic           host_we,
   input  logic [1:0]     host_addr,
   input  logic [W-1:0]   host_wdata,
   input  logic [W-1:0]   out_head,
   input  logic [OCW-1:0] out_count,
   input  logic [ICW-1:0] in_count,
   output logic           in_push,
   output logic [W-1:0]   in_data,
   output logic           out_pop,
   output logic [W-1:0]   host_rdata
);

   mbx_addr_e      sel_addr;
   logic           rd_cyc;
   logic [ICW-1:0] in_free;
   logic [W-1:0]   status;

   assign sel_addr = mbx_addr_e'(host_addr);
   assign rd_cyc   = host_sel && !host_we;
   assign in_push  = host_sel && host_we && (sel_addr == MBX_A_INMSG);
   assign in_data  = host_wdata;
   assign out_pop  = rd_cyc && (sel_addr == MBX_A_OUTMSG) && (out_count != '0);
   assign in_free  = ICW'(IN_DEPTH) - in_count;

   always_comb begin
      status = '0;
      status[STAT_OUT_LSB +: STAT_FIELD_W] = STAT_FIELD_W'(out_count);
      status[STAT_IN_LSB  +: STAT_FIELD_W] = STAT_FIELD_W'(in_free);
   end

   always_comb begin
      host_rdata = '0;
      if (rd_cyc) begin
         unique case (sel_addr)
            MBX_A_OUTMSG: host_rdata = (out_count != '0) ? out_head : '0;
            MBX_A_STATUS: host_rdata = status;
            default:      host_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/mbx_core_if.sv
module mbx_core_if #(
   parameter int W         = 32,
   parameter int OUT_DEPTH = 1,
   localparam int OCW      = $clog2(OUT_DEPTH + 1)
) (
   input  logic           core_rd_req,
   input  logic           core_wr_req,
   input  logic           in_empty,
   input  logic [W-1:0]   in_head,
   input  logic           out_full,
   input  logic           out_pop,
   input  logic [OCW-1:0] out_count,
   output logic           core_rd_ack,
   output logic [W-1:0]   core_rd_data,
   output logic           core_wr_ack,
   output logic [OCW-1:0] core_out_space
);

   assign core_rd_ack    = core_rd_req && !in_empty;
   assign core_rd_data   = core_rd_ack ? in_head : '0;
   assign core_wr_ack    = core_wr_req && (!out_full || out_pop);
   assign core_out_space = OCW'(OUT_DEPTH) - out_count;

endmodule

// File: rtl/mailbox_pair.sv
module mailbox_pair
   import mbx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IN_DEPTH  = 4,
   parameter int OUT_DEPTH = 1,
   localparam int ICW      = $clog2(IN_DEPTH + 1),
   localparam int OCW      = $clog2(OUT_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_rd_req,
   output logic              core_rd_ack,
   output logic [DATA_W-1:0] core_rd_data,
   input  logic              core_wr_req,
   input  logic [DATA_W-1:0] core_wr_data,
   output logic              core_wr_ack,
   output logic [ICW-1:0]    core_in_count,
   output logic [OCW-1:0]    core_out_space,
   input  logic              host_sel,
   input  logic              host_we,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata
);

   generate
      if (DATA_W < STAT_IN_LSB + STAT_FIELD_W) begin : g_bad_width
         $error("mailbox_pair: DATA_W too narrow for the status word");
      end
      if (IN_DEPTH < 1 || IN_DEPTH > STAT_MAX_DEPTH) begin : g_bad_in
         $error("mailbox_pair: IN_DEPTH out of range");
      end
      if (OUT_DEPTH < 1 || OUT_DEPTH > STAT_MAX_DEPTH) begin : g_bad_out
         $error("mailbox_pair: OUT_DEPTH out of range");
      end
   endgenerate

   logic              in_push, in_full, in_empty;
   logic [DATA_W-1:0] in_data, in_head;
   logic [ICW-1:0]    in_count;
   logic              out_pop, out_full, out_empty;
   logic [DATA_W-1:0] out_head;
   logic [OCW-1:0]    out_count;

   mbx_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH), .OVERWRITE(1'b1)) u_inbound (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (in_push),
      .push_data (in_data),
      .pop       (core_rd_ack),
      .head      (in_head),
      .count     (in_count),
      .full      (in_full),
      .empty     (in_empty)
   );

   mbx_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH), .OVERWRITE(1'b0)) u_outbound (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (core_wr_ack),
      .push_data (core_wr_data),
      .pop       (out_pop),
      .head      (out_head),
      .count     (out_count),
      .full      (out_full),
      .empty     (out_empty)
   );

   mbx_host_if #(.W(DATA_W), .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) u_host (
      .host_sel   (host_sel),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .out_head   (out_head),
      .out_count  (out_count),
      .in_count   (in_count),
      .in_push    (in_push),
      .in_data    (in_data),
      .out_pop    (out_pop),
      .host_rdata (host_rdata)
   );

   mbx_core_if #(.W(DATA_W), .OUT_DEPTH(OUT_DEPTH)) u_core (
      .core_rd_req    (core_rd_req),
      .core_wr_req    (core_wr_req),
      .in_empty       (in_empty),
      .in_head        (in_head),
      .out_full       (out_full),
      .out_pop        (out_pop),
      .out_count      (out_count),
      .core_rd_ack    (core_rd_ack),
      .core_rd_data   (core_rd_data),
      .core_wr_ack    (core_wr_ack),
      .core_out_space (core_out_space)
   );

   assign core_in_count = in_count;

   logic unused_flags;
   assign unused_flags = in_full ^ out_empty;

endmodule

// File: rtl/mailbox_pair_chk.sv
module mailbox_pair_chk #(
   parameter int DATA_W    = 32,
   parameter int IN_DEPTH  = 4,
   parameter int OUT_DEPTH = 1,
   localparam int ICW      = $clog2(IN_DEPTH + 1),
   localparam int OCW      = $clog2(OUT_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              core_rd_req,
   input logic              core_rd_ack,
   input logic              core_wr_req,
   input logic              core_wr_ack,
   input logic [ICW-1:0]    core_in_count,
   input logic [OCW-1:0]    core_out_space,
   input logic              host_sel,
   input logic              host_we,
   input logic [1:0]        host_addr,
   input logic [DATA_W-1:0] host_rdata
);

   logic           host_out_rd, host_in_wr, host_stat_rd;
   logic [7:0]     exp_out_cnt, exp_in_free;
   logic [ICW-1:0] in_cnt_dec;

   assign host_out_rd  = host_sel && !host_we && (host_addr == 2'd0);
   assign host_in_wr   = host_sel &&  host_we && (host_addr == 2'd1);
   assign host_stat_rd = host_sel && !host_we && (host_addr == 2'd2);
   assign exp_out_cnt  = 8'(OUT_DEPTH) - 8'(core_out_space);
   assign exp_in_free  = 8'(IN_DEPTH) - 8'(core_in_count);
   assign in_cnt_dec   = core_in_count - ICW'(1);

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      core_in_count <= ICW'(IN_DEPTH));

   assert_rd_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (core_in_count == '0) |-> !core_rd_ack);

   assert_wr_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (core_wr_req && core_out_space == '0 && !host_out_rd) |-> !core_wr_ack);

   assert_pop_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rd_ack && !host_in_wr) |=> (core_in_count == $past(in_cnt_dec)));

   assert_empty_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_out_rd && core_out_space == OCW'(OUT_DEPTH)) |-> (host_rdata == '0));

   assert_empty_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_out_rd && core_out_space == OCW'(OUT_DEPTH) && !core_wr_req)
      |=> (core_out_space == OCW'(OUT_DEPTH)));

   assert_full_ovw_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_in_wr && core_in_count == ICW'(IN_DEPTH) && !core_rd_req)
      |=> (core_in_count == ICW'(IN_DEPTH)));

   assert_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_stat_rd |-> (host_rdata[7:0] == exp_out_cnt && host_rdata[15:8] == exp_in_free));

   assert_in_pushpop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_in_wr && core_rd_ack) |=> $stable(core_in_count));

   assert_out_pushpop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (core_wr_ack && host_out_rd && core_out_space == '0) |=> $stable(core_out_space));

endmodule

bind mailbox_pair mailbox_pair_chk #(
   .DATA_W    (DATA_W),
   .IN_DEPTH  (IN_DEPTH),
   .OUT_DEPTH (OUT_DEPTH)
) u_mailbox_pair_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .core_rd_req    (core_rd_req),
   .core_rd_ack    (core_rd_ack),
   .core_wr_req    (core_wr_req),
   .core_wr_ack    (core_wr_ack),
   .core_in_count  (core_in_count),
   .core_out_space (core_out_space),
   .host_sel       (host_sel),
   .host_we        (host_we),
   .host_addr      (host_addr),
   .host_rdata     (host_rdata)
);

// File: tb/test_mailbox_pair.sv
module test_mailbox_pair;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        core_rd_req, core_wr_req, core_rd_ack, core_wr_ack;
   logic [31:0] core_rd_data, core_wr_data;
   logic [2:0]  core_in_count;
   logic [0:0]  core_out_space;
   logic        host_sel, host_we;
   logic [1:0]  host_addr;
   logic [31:0] host_wdata, host_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   mailbox_pair i_mailbox_pair (
      .clk(clk), .rst_n(rst_n),
      .core_rd_req(core_rd_req), .core_rd_ack(core_rd_ack), .core_rd_data(core_rd_data),
      .core_wr_req(core_wr_req), .core_wr_data(core_wr_data), .core_wr_ack(core_wr_ack),
      .core_in_count(core_in_count), .core_out_space(core_out_space),
      .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle: inputs set after the falling edge, outputs settle 2 ns later
   task automatic cyc(input logic hs, input logic hw, input logic [1:0] ha,
                      input logic [31:0] hd, input logic crd, input logic cwr,
                      input logic [31:0] cwd);
      @(negedge clk);
      host_sel = hs; host_we = hw; host_addr = ha; host_wdata = hd;
      core_rd_req = crd; core_wr_req = cwr; core_wr_data = cwd;
      #2;
   endtask

   task automatic idle();
      cyc(0, 0, 2'd0, 32'h0, 0, 0, 32'h0);
   endtask

   task automatic hwr(input logic [1:0] a, input logic [31:0] d);
      cyc(1, 1, a, d, 0, 0, 32'h0);
   endtask

   task automatic hrd(input logic [1:0] a, output logic [31:0] d);
      cyc(1, 0, a, 32'h0, 0, 0, 32'h0);
      d = host_rdata;
   endtask

   task automatic core_take(input string tag, input logic [31:0] exp);
      cyc(0, 0, 2'd0, 32'h0, 1, 0, 32'h0);
      check({tag, " ack"}, 32'(core_rd_ack), 32'h1);
      check({tag, " data"}, core_rd_data, exp);
   endtask

   task automatic t_reset();
      logic [31:0] r;
      idle();
      check("R9 in_count", 32'(core_in_count), 32'h0);
      check("R9 out_space", 32'(core_out_space), 32'h1);
      hrd(2'd2, r);
      check("R9 status", r, 32'h0000_0400);
      cyc(0, 0, 2'd0, 32'h0, 1, 0, 32'h0);
      check("R9 no rd_ack", 32'(core_rd_ack), 32'h0);
   endtask

   task automatic t_fifo_order();
      logic [31:0] r;
      hwr(2'd1, 32'hFFFF_FFFF);
      hwr(2'd1, 32'h8000_0001);
      hwr(2'd1, 32'h1234_5678);
      hwr(2'd1, 32'h0000_0000);
      idle();
      check("R5 in_count 4", 32'(core_in_count), 32'h4);
      hrd(2'd2, r);
      check("R8 status full in", r, 32'h0000_0000);
      check("R5 count no side effect", 32'(core_in_count), 32'h4);
      core_take("R2 R1 first", 32'hFFFF_FFFF);
      idle();
      check("R5 dec after read", 32'(core_in_count), 32'h3);
      core_take("R2 R1 second", 32'h8000_0001);
      core_take("R2 third", 32'h1234_5678);
      core_take("R2 fourth", 32'h0000_0000);
      idle();
      check("R2 drained", 32'(core_in_count), 32'h0);
   endtask

   task automatic t_rd_stall();
      for (int i = 0; i < 3; i++) begin
         cyc(0, 0, 2'd0, 32'h0, 1, 0, 32'h0);
         check("R3 stall while empty", 32'(core_rd_ack), 32'h0);
      end
      cyc(1, 1, 2'd1, 32'hCAFE_F00D, 1, 0, 32'h0);
      check("R3 no ack in write cycle", 32'(core_rd_ack), 32'h0);
      core_take("R3 released", 32'hCAFE_F00D);
      idle();
      check("R3 count after", 32'(core_in_count), 32'h0);
   endtask

   task automatic t_wr_stall();
      logic [31:0] r;
      cyc(0, 0, 2'd0, 32'h0, 0, 1, 32'hDEAD_BEEF);
      check("R4 first write ack", 32'(core_wr_ack), 32'h1);
      idle();
      check("R5 out_space 0", 32'(core_out_space), 32'h0);
      hrd(2'd2, r);
      check("R8 status out 1", r, 32'h0000_0401);
      for (int i = 0; i < 2; i++) begin
         cyc(0, 0, 2'd0, 32'h0, 0, 1, 32'h0BAD_CAFE);
         check("R4 stall while full", 32'(core_wr_ack), 32'h0);
      end
      cyc(1, 0, 2'd0, 32'h0, 0, 1, 32'h0BAD_CAFE);
      check("R10 out host data", host_rdata, 32'hDEAD_BEEF);
      check("R10 out core ack", 32'(core_wr_ack), 32'h1);
      idle();
      check("R10 out count held", 32'(core_out_space), 32'h0);
      hrd(2'd0, r);
      check("R10 R1 second message", r, 32'h0BAD_CAFE);
      idle();
      check("R4 space back", 32'(core_out_space), 32'h1);
      hrd(2'd0, r);
      check("R6 empty read zero", r, 32'h0);
      idle();
      check("R6 space unchanged", 32'(core_out_space), 32'h1);
      hrd(2'd2, r);
      check("R6 status unchanged", r, 32'h0000_0400);
   endtask

   task automatic t_overwrite();
      for (int i = 1; i <= 5; i++) hwr(2'd1, 32'(i) | 32'hA500_0000);
      idle();
      check("R7 count stays 4", 32'(core_in_count), 32'h4);
      core_take("R7 keep 1", 32'hA500_0001);
      core_take("R7 keep 2", 32'hA500_0002);
      core_take("R7 keep 3", 32'hA500_0003);
      core_take("R7 newest replaced", 32'hA500_0005);
      idle();
      check("R7 drained", 32'(core_in_count), 32'h0);
   endtask

   task automatic t_in_same_cycle();
      hwr(2'd1, 32'h0000_00A1);
      hwr(2'd1, 32'h0000_00B2);
      cyc(1, 1, 2'd1, 32'h0000_00C3, 1, 0, 32'h0);
      check("R10 in pop data", core_rd_data, 32'h0000_00A1);
      idle();
      check("R10 in count held", 32'(core_in_count), 32'h2);
      hwr(2'd1, 32'h0000_00D4);
      hwr(2'd1, 32'h0000_00E5);
      cyc(1, 1, 2'd1, 32'h0000_00F6, 1, 0, 32'h0);
      check("R10 full pop data", core_rd_data, 32'h0000_00B2);
      idle();
      check("R10 full count held", 32'(core_in_count), 32'h4);
      core_take("R10 order C", 32'h0000_00C3);
      core_take("R10 order D", 32'h0000_00D4);
      core_take("R10 order E", 32'h0000_00E5);
      core_take("R10 no loss F", 32'h0000_00F6);
   endtask

   task automatic t_addr_map();
      logic [31:0] r;
      hwr(2'd0, 32'h1111_1111);
      hwr(2'd2, 32'h2222_2222);
      hwr(2'd3, 32'h3333_3333);
      idle();
      check("R11 in untouched", 32'(core_in_count), 32'h0);
      check("R11 out untouched", 32'(core_out_space), 32'h1);
      hrd(2'd2, r);
      check("R11 status untouched", r, 32'h0000_0400);
      cyc(0, 0, 2'd0, 32'h0, 0, 1, 32'h5A5A_A5A5);
      hrd(2'd1, r);
      check("R11 addr1 read zero", r, 32'h0);
      hrd(2'd3, r);
      check("R11 addr3 read zero", r, 32'h0);
      idle();
      check("R11 no pop by addr1/3", 32'(core_out_space), 32'h0);
      hrd(2'd0, r);
      check("R11 message kept", r, 32'h5A5A_A5A5);
      idle();
   endtask

   initial begin
      rst_n = 1'b0;
      host_sel = 0; host_we = 0; host_addr = 0; host_wdata = 0;
      core_rd_req = 0; core_wr_req = 0; core_wr_data = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fifo_order();
      t_rd_stall();
      t_wr_stall();
      t_overwrite();
      t_in_same_cycle();
      t_addr_map();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule